// File: doc/BRIEF.md
# Local-to-PCI Memory Window Translator

This block converts CPU-side physical addresses into 32-bit PCI memory addresses. Three adjacent 64 MB local windows cover 0x1000_0000 up to 0x1BFF_FFFF, a 192 MB span. For each window, a 6-bit field in one packed map register supplies PCI address bits [31:26]. The low 26 bits of the local address pass straight through. An address outside the span leaves the block unchanged and is flagged as a miss.

A request is a local address qualified by a valid strobe. One clock later the block returns the translated address, a hit flag and the index of the window that matched. Software reads and writes the map register through a small register port. A single control bit sits above the three window fields. It is stored and brought out as a level, and it plays no part in translation.

Top module: `pci_win_xlate`

## Requirements
- R1: After reset the map register reads 0, `map_flag` is 0, and `rsp_valid` and `rsp_hit` are both 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[18:0]`. `cfg_rdata` then returns those bits, and bits [31:19] read as 0.
- R3: An address in 0x1000_0000..0x13FF_FFFF hits window 0 (`rsp_win` = 0). The result is map bits [5:0] followed by local bits [25:0].
- R4: An address in 0x1400_0000..0x17FF_FFFF hits window 1 (`rsp_win` = 1). The result is map bits [11:6] followed by local bits [25:0].
- R5: An address in 0x1800_0000..0x1BFF_FFFF hits window 2 (`rsp_win` = 2). The result is map bits [17:12] followed by local bits [25:0].
- R6: Any address below 0x1000_0000 or above 0x1BFF_FFFF gives `rsp_hit` = 0 and `rsp_win` = 0. `rsp_addr` then equals the local address unchanged, including addresses that differ from a window only in bits [31:29].
- R7: `rsp_valid` follows `req_valid` one clock later. The result for a request appears in that same cycle. When `rsp_valid` is 0, `rsp_hit` is 0.
- R8: When a map write and a request share a clock edge, the request is translated with the map value from before the write. The new value applies to requests from the next edge on.
- R9: Map bit 18 appears on `map_flag`. Its value does not change any translation result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_wdata | input | 32 | Map register write data |
| cfg_rdata | output | 32 | Map register read-back, upper bits zero |
| map_flag | output | 1 | Control bit stored above the window fields |
| req_valid | input | 1 | Local address is valid |
| req_addr | input | 32 | Local physical address |
| rsp_valid | output | 1 | Translation result is valid |
| rsp_hit | output | 1 | Address fell inside a window |
| rsp_win | output | 2 | Index of the matching window |
| rsp_addr | output | 32 | Translated PCI address, or the local address on a miss |

## Verification
A map write and a translation can land on the same clock edge. The question then is which field value the translation uses. The bench provokes this by raising `cfg_we` with a new map value in the same cycle as a window-0 request. It checks that the response carries the old field. It then checks that the next request to the same address carries the new field. The checker compares every hit against the field taken from the read-back value one cycle earlier, so the same ordering is judged on every translation.

// File: rtl/pcix_pkg.sv
package pcix_pkg;
  // Defaults shared by the translator and its checker
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_WIN_BITS = 26;            // 64 MB windows
  localparam int unsigned DEF_NUM_WIN  = 3;
  localparam logic [31:0] DEF_BASE     = 32'h1000_0000; // first window
endpackage

// File: rtl/pcix_map_reg.sv
module pcix_map_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned NUM_WIN = 3,
  localparam int unsigned REG_W  = NUM_WIN * FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [REG_W-1:0]  map_q,
  output logic [ADDR_W-1:0] rdata,
  output logic              flag
);
  always_ff @(posedge clk) begin
    if (rst)     map_q <= '0;
    else if (we) map_q <= wdata[REG_W-1:0];
  end

  assign rdata = {{(ADDR_W-REG_W){1'b0}}, map_q};
  assign flag  = map_q[REG_W-1];
endmodule

// File: rtl/pcix_win_decode.sv
module pcix_win_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 26,
  parameter int unsigned NUM_WIN  = 3,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000,
  localparam int unsigned TOP_W   = ADDR_W - WIN_BITS,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [TOP_W-1:0] BASE_TOP = BASE[ADDR_W-1:WIN_BITS];

  logic [NUM_WIN-1:0] hit_vec;

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    assign hit_vec[n] = (addr[ADDR_W-1:WIN_BITS] == BASE_TOP + TOP_W'(n));
  end

  always_comb begin
    idx = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (hit_vec[n]) idx = IDX_W'(n);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/pcix_compose.sv
module pcix_compose #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 26,
  parameter int unsigned NUM_WIN  = 3,
  localparam int unsigned FIELD_W = ADDR_W - WIN_BITS,
  localparam int unsigned REG_W   = NUM_WIN * FIELD_W + 1,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  map_q,
  output logic [ADDR_W-1:0] xaddr
);
  logic [FIELD_W-1:0] fld [NUM_WIN];
  logic [FIELD_W-1:0] sel;

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_fld
    assign fld[n] = map_q[n*FIELD_W +: FIELD_W];
  end

  always_comb begin
    sel = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (idx == IDX_W'(n)) sel = fld[n];
    end
  end

  assign xaddr = hit ? {sel, addr[WIN_BITS-1:0]} : addr;
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
  import pcix_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned WIN_BITS = DEF_WIN_BITS,
  parameter int unsigned NUM_WIN  = DEF_NUM_WIN,
  parameter logic [ADDR_W-1:0] BASE = DEF_BASE,
  localparam int unsigned FIELD_W = ADDR_W - WIN_BITS,
  localparam int unsigned REG_W   = NUM_WIN * FIELD_W + 1,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              map_flag,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic [REG_W-1:0]  map_q;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] xaddr;

  pcix_map_reg #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .NUM_WIN(NUM_WIN)) u_map (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .map_q(map_q), .rdata(cfg_rdata), .flag(map_flag)
  );

  pcix_win_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN),
                    .BASE(BASE)) u_dec (
    .addr(req_addr), .hit(dec_hit), .idx(dec_idx)
  );

  pcix_compose #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN)) u_cmp (
    .addr(req_addr), .hit(dec_hit), .idx(dec_idx), .map_q(map_q), .xaddr(xaddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & dec_hit;
      if (req_valid) begin
        rsp_addr <= xaddr;
        rsp_win  <= dec_hit ? dec_idx : '0;
      end
    end
  end
endmodule

// File: rtl/pcix_xlate_chk.sv
module pcix_xlate_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 26,
  parameter int unsigned NUM_WIN  = 3,
  localparam int unsigned FIELD_W = ADDR_W - WIN_BITS,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              map_flag,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_win,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam int unsigned FLAG_POS = NUM_WIN * FIELD_W;

  logic [ADDR_W-1:0]  prev_map;
  logic [FIELD_W-1:0] exp_field;

  always_ff @(posedge clk) prev_map <= cfg_rdata;
  assign exp_field = FIELD_W'(prev_map >> (32'(rsp_win) * FIELD_W));

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R7
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit); // R7
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & ((ADDR_W'(1) << (FLAG_POS+1)) - 1))); // R2
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_addr == $past(req_addr) && rsp_win == '0); // R6
  AST_HIT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_addr[WIN_BITS-1:0] == $past(req_addr[WIN_BITS-1:0])); // R3
  AST_HIT_OLD_FIELD: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_addr[ADDR_W-1:WIN_BITS] == exp_field); // R8
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> 32'(rsp_win) < NUM_WIN); // R5
  AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> map_flag == $past(cfg_wdata[FLAG_POS])); // R9
endmodule

bind pci_win_xlate pcix_xlate_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .map_flag(map_flag), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
);

// File: tb/pci_win_xlate_bench.sv
`timescale 1ns/1ps
module pci_win_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        map_flag;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pci_win_xlate u_pci_win_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .map_flag(map_flag), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  // map 0xA87F: win0 field 0x3F, win1 field 0x21, win2 field 0x0A
  // vector = {local addr, exp hit, exp win, exp pci addr}
  localparam logic [66:0] VEC [11] = '{
    {32'h1000_0000, 1'b1, 2'd0, 32'hFC00_0000},   // R3
    {32'h13FF_FFFF, 1'b1, 2'd0, 32'hFFFF_FFFF},   // R3
    {32'h1400_0000, 1'b1, 2'd1, 32'h8400_0000},   // R4
    {32'h17AB_CDEF, 1'b1, 2'd1, 32'h87AB_CDEF},   // R4
    {32'h1800_0000, 1'b1, 2'd2, 32'h2800_0000},   // R5
    {32'h1BFF_FFFF, 1'b1, 2'd2, 32'h2BFF_FFFF},   // R5
    {32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0FFF_FFFF},   // R6
    {32'h1C00_0000, 1'b0, 2'd0, 32'h1C00_0000},   // R6
    {32'h0000_0000, 1'b0, 2'd0, 32'h0000_0000},   // R6
    {32'hFFFF_FFFF, 1'b0, 2'd0, 32'hFFFF_FFFF},   // R6
    {32'h9000_0000, 1'b0, 2'd0, 32'h9000_0000}    // R6 alias in top bits
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_map(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string req, input logic h, input logic [1:0] w,
                           input logic [31:0] pa);
    check(req, {31'd0, rsp_valid}, 32'd1);
    check(req, {31'd0, rsp_hit}, {31'd0, h});
    check(req, {30'd0, rsp_win}, {30'd0, w});
    check(req, rsp_addr, pa);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", cfg_rdata, 32'h0);
    check("R1", {31'd0, map_flag}, 32'd0);
    check("R1", {31'd0, rsp_valid}, 32'd0);
    check("R1", {31'd0, rsp_hit}, 32'd0);

    // R2 read-back masks upper bits
    write_map(32'hFFFF_FFFF);
    check("R2", cfg_rdata, 32'h0007_FFFF);
    check("R9", {31'd0, map_flag}, 32'd1);

    // table walk
    write_map(32'h0000_A87F);
    check("R2", cfg_rdata, 32'h0000_A87F);
    for (int i = 0; i < 11; i++) begin
      xlate(VEC[i][66:35]);
      check_rsp($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i][34], VEC[i][33:32], VEC[i][31:0]);
    end

    // R7 no request: valid and hit low
    @(negedge clk);
    check("R7", {31'd0, rsp_valid}, 32'd0);
    check("R7", {31'd0, rsp_hit}, 32'd0);

    // R9 flag set does not change translation
    write_map(32'h0004_A87F);
    check("R9", {31'd0, map_flag}, 32'd1);
    xlate(32'h17AB_CDEF);
    check_rsp("R9", 1'b1, 2'd1, 32'h87AB_CDEF);
    xlate(32'h1BFF_FFFF);
    check_rsp("R9", 1'b1, 2'd2, 32'h2BFF_FFFF);

    // R8 write and request on same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0000;
    req_valid = 1'b1; req_addr = 32'h1000_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check_rsp("R8 old map", 1'b1, 2'd0, 32'hFC00_0000);
    xlate(32'h1000_0000);
    check_rsp("R8 new map", 1'b1, 2'd0, 32'h0000_0000);

    // typical layout: 0 MB, 320 MB, 384 MB
    write_map(32'h0000_6140);
    xlate(32'h1412_3456);
    check_rsp("R4", 1'b1, 2'd1, 32'h1412_3456);
    xlate(32'h1000_0010);
    check_rsp("R3", 1'b1, 2'd0, 32'h0000_0010);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule